// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is the external bus controller of a small 8-bit processor with a 13-bit address space. The core hands it one read or write request at a time, with an address and, for a write, a data byte. The controller runs that request as one external bus cycle. The top five address bits go out on a dedicated output. The low address byte and the data byte take turns on a single shared 8-bit bus.

Every cycle walks through the same four phases: an address-strobe phase, an address-hold phase, a data-strobe phase and a closing phase. In the address-strobe phase the address strobe is high and the low address is on the shared bus. In the address-hold phase the strobe is low and the address stays on the bus, so the outside world can latch it. In the data-strobe phase the data strobe is high. For a write the controller drives the write byte. For a read it releases the shared bus and samples it at the falling edge of the data strobe. The closing phase carries a one-cycle completion pulse, and for a read the captured byte comes with it.

The length of each strobe phase is a parameter counted in cycles of the internal clock. A new request is taken only while the controller is idle. A request presented while a cycle is running waits, unchanged, until the controller is idle again.

Top module: `muxbus_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the controller is idle. Both strobes are low, the read/write line is high, the shared-bus enable is low, `req_ready` is high and `rsp_done` is low.
- R2: From the first address-strobe cycle through the closing cycle, `bus_hi_addr` equals request address bits 12..8, and it holds steady through the whole cycle.
- R3: One clock after acceptance, `bus_addr_stb` is high for ASH_CYC cycles and then low for ASL_CYC cycles. In both phases `bus_ad_out` carries address bits 7..0 and `bus_ad_oe` is 1.
- R4: `bus_data_stb` is high for DSH_CYC cycles immediately after the address-hold phase. The two strobes are never high at the same time.
- R5: `bus_rd_wr_n` is 1 for a read and 0 for a write. It holds that value from the first address-strobe cycle through the closing cycle, and it is 1 while idle.
- R6: In a write, during the data-strobe phase and the closing cycle, `bus_ad_out` equals the write byte and `bus_ad_oe` is 1.
- R7: In a read, `bus_ad_oe` is 0 during the data-strobe phase and the closing cycle.
- R8: In a read, `rsp_rdata` equals the value of `bus_ad_in` sampled at the clock edge that ends the last data-strobe cycle. A value present only in earlier data-strobe cycles has no effect on it.
- R9: `rsp_done` is high for exactly one cycle: the cycle right after the data strobe falls. It is low again in the following idle cycle.
- R10: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the first address-strobe cycle through the closing cycle. A request held during a running cycle does not alter that cycle, and it is started after the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with `rsp_done` |
| bus_hi_addr | output | 5 | Dedicated upper address bits |
| bus_ad_out | output | 8 | Shared bus, driven value |
| bus_ad_oe | output | 1 | Shared bus output enable |
| bus_ad_in | input | 8 | Shared bus, received value |
| bus_addr_stb | output | 1 | Address strobe |
| bus_data_stb | output | 1 | Data strobe |
| bus_rd_wr_n | output | 1 | High for read, low for write |

## Verification
The bench mixes random reads and writes with directed addresses at the extremes: all zeros, all ones, upper bits only and lower bits only. A fault in how the address is split between the dedicated output and the shared bus then shows up as a wrong latched address.

During a read, the external model drives a decoy byte in the earlier data-strobe cycles and the true byte only in the last one. This separates capture at the fall of the data strobe from capture one cycle early or late. The true byte is derived from the address the model itself latched from the bus.

A back-to-back case holds a second request on the inputs during a running cycle. This shows that the held request neither disturbs the current cycle nor is lost.

// File: rtl/muxbus_pkg.sv
`timescale 1ns/1ps
// Package: shared phase encoding for the multiplexed bus controller.
package muxbus_pkg;
    // Bus cycle phases, in the order they are visited.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_HOLD = 3'd2,
        PH_DATA = 3'd3,
        PH_END  = 3'd4
    } bus_phase_e;
endpackage

// File: rtl/muxbus_phase_seq.sv
`timescale 1ns/1ps
// Module: muxbus_phase_seq
// Walks one bus cycle through address-strobe, address-hold, data-strobe and
// closing phases. Each strobe phase lasts a parameterised number of clocks.
// Assumes: start is only raised while idle; every length is at least 1.
module muxbus_phase_seq
    import muxbus_pkg::*;
#(
    parameter int unsigned ASH_CYC = 2,
    parameter int unsigned ASL_CYC = 1,
    parameter int unsigned DSH_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output bus_phase_e phase,
    output logic       phase_last
);
    localparam int unsigned MAX_A   = (ASH_CYC > ASL_CYC) ? ASH_CYC : ASL_CYC;
    localparam int unsigned MAX_LEN = (MAX_A > DSH_CYC) ? MAX_A : DSH_CYC;
    localparam int unsigned CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam logic [CNT_W-1:0] ASH_LD = CNT_W'(ASH_CYC - 1);
    localparam logic [CNT_W-1:0] ASL_LD = CNT_W'(ASL_CYC - 1);
    localparam logic [CNT_W-1:0] DSH_LD = CNT_W'(DSH_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Last cycle of the current phase.
    assign phase_last = (cnt_q == '0);

    // Phase state and remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_ADDR;
                    cnt_q <= ASH_LD;
                end
                PH_ADDR: if (phase_last) begin
                    phase <= PH_HOLD;
                    cnt_q <= ASL_LD;
                end else cnt_q <= cnt_q - 1'b1;
                PH_HOLD: if (phase_last) begin
                    phase <= PH_DATA;
                    cnt_q <= DSH_LD;
                end else cnt_q <= cnt_q - 1'b1;
                PH_DATA: if (phase_last) begin
                    phase <= PH_END;
                    cnt_q <= '0;
                end else cnt_q <= cnt_q - 1'b1;
                PH_END: begin
                    phase <= PH_IDLE;
                    cnt_q <= '0;
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // R3/R4: phases change only along the fixed order.
    a_r4_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |->
            ((phase == PH_ADDR && $past(phase) == PH_IDLE) ||
             (phase == PH_HOLD && $past(phase) == PH_ADDR) ||
             (phase == PH_DATA && $past(phase) == PH_HOLD) ||
             (phase == PH_END  && $past(phase) == PH_DATA) ||
             (phase == PH_IDLE && $past(phase) == PH_END)));

    // R9: the closing phase lasts exactly one cycle.
    a_r9_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_END) |=> (phase == PH_IDLE));
endmodule

// File: rtl/muxbus_req_hold.sv
`timescale 1ns/1ps
// Module: muxbus_req_hold
// Takes the request fields on acceptance and holds them for the whole cycle.
// Assumes: accept is raised only while the controller is idle.
module muxbus_req_hold #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              hold_write,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_wdata
);
    // Request field registers, loaded on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_write <= 1'b0;
            hold_addr  <= '0;
            hold_wdata <= '0;
        end else if (accept) begin
            hold_write <= in_write;
            hold_addr  <= in_addr;
            hold_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/muxbus_rd_capture.sv
`timescale 1ns/1ps
// Module: muxbus_rd_capture
// Samples the shared bus at the edge that ends the data strobe of a read.
// Assumes: data_last is high only in the final data-strobe cycle.
module muxbus_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_last,
    input  logic              is_write,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata
);
    logic cap_en;

    // Capture only on a read, at the strobe's falling edge.
    assign cap_en = data_last && !is_write;

    // Read byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (cap_en) rdata <= bus_in;
    end
endmodule

// File: rtl/muxbus_ctrl.sv
`timescale 1ns/1ps
// Module: muxbus_ctrl (top)
// External bus controller. The upper address bits go out on a dedicated
// output; the low address byte and the data share one 8-bit bus.
// Assumes: a requester keeps req_valid and the fields steady until accepted.
module muxbus_ctrl
    import muxbus_pkg::*;
#(
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ASH_CYC = 2,
    parameter int unsigned ASL_CYC = 1,
    parameter int unsigned DSH_CYC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [ADDR_W-DATA_W-1:0] bus_hi_addr,
    output logic [DATA_W-1:0]        bus_ad_out,
    output logic                     bus_ad_oe,
    input  logic [DATA_W-1:0]        bus_ad_in,
    output logic                     bus_addr_stb,
    output logic                     bus_data_stb,
    output logic                     bus_rd_wr_n
);
    localparam int unsigned HI_W = ADDR_W - DATA_W;

    bus_phase_e        phase;
    logic              phase_last;
    logic              accept;
    logic              hold_write;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_wdata;
    logic              addr_ph;
    logic              wdat_ph;

    // Acceptance happens only while idle.
    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    muxbus_phase_seq #(
        .ASH_CYC (ASH_CYC),
        .ASL_CYC (ASL_CYC),
        .DSH_CYC (DSH_CYC)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .phase      (phase),
        .phase_last (phase_last)
    );

    muxbus_req_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .in_write   (req_write),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .hold_write (hold_write),
        .hold_addr  (hold_addr),
        .hold_wdata (hold_wdata)
    );

    muxbus_rd_capture #(
        .DATA_W (DATA_W)
    ) i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_last ((phase == PH_DATA) && phase_last),
        .is_write  (hold_write),
        .bus_in    (bus_ad_in),
        .rdata     (rsp_rdata)
    );

    // Strobe, direction and shared-bus drive decode from the current phase.
    always_comb begin
        addr_ph      = (phase == PH_ADDR) || (phase == PH_HOLD);
        wdat_ph      = hold_write && ((phase == PH_DATA) || (phase == PH_END));
        bus_addr_stb = (phase == PH_ADDR);
        bus_data_stb = (phase == PH_DATA);
        bus_rd_wr_n  = (phase == PH_IDLE) ? 1'b1 : !hold_write;
        bus_hi_addr  = hold_addr[ADDR_W-1 -: HI_W];
        bus_ad_out   = addr_ph ? hold_addr[DATA_W-1:0] : hold_wdata;
        bus_ad_oe    = addr_ph || wdat_ph;
        rsp_done     = (phase == PH_END);
    end

    // R4: the two strobes never overlap.
    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_addr_stb && bus_data_stb));

    // R5: direction line holds through a running cycle.
    a_r5_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(bus_rd_wr_n));

    // R2: upper address holds through a running cycle.
    a_r2_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(bus_hi_addr));

    // R7: no drive on the shared bus while a read's data strobe is high.
    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_stb && bus_rd_wr_n) |-> !bus_ad_oe);

    // R9: completion comes right after the data strobe falls.
    a_r9_done_after_ds: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ($past(bus_data_stb) && !bus_data_stb));

    // R10: a held request cannot start while a cycle runs.
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !rsp_done) |=> !req_ready);
endmodule

// File: tb/test_muxbus_ctrl.sv
`timescale 1ns/1ps
// Bench for muxbus_ctrl: directed corner cases plus seeded random traffic.
module test_muxbus_ctrl;
    localparam int ASH = 2;
    localparam int ASL = 1;
    localparam int DSH = 2;
    localparam int TOT = ASH + ASL + DSH + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [4:0]  bus_hi_addr;
    logic [7:0]  bus_ad_out;
    logic        bus_ad_oe;
    logic [7:0]  bus_ad_in = '0;
    logic        bus_addr_stb;
    logic        bus_data_stb;
    logic        bus_rd_wr_n;
    logic [12:0] dev_addr = '0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    muxbus_ctrl #(.ASH_CYC(ASH), .ASL_CYC(ASL), .DSH_CYC(DSH)) i_muxbus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_hi_addr(bus_hi_addr),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_addr_stb(bus_addr_stb), .bus_data_stb(bus_data_stb),
        .bus_rd_wr_n(bus_rd_wr_n));

    // External model latches the full address at the fall of the address strobe.
    always @(negedge bus_addr_stb) dev_addr = {bus_hi_addr, bus_ad_out};

    // External memory contents, a function of the address.
    function automatic logic [7:0] rd_fn(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Runs one transfer starting at an idle negedge; optionally holds a next request.
    task automatic xfer(input bit w, input logic [12:0] a, input logic [7:0] d,
                        input bit hold_next, input bit nw,
                        input logic [12:0] na, input logic [7:0] nd);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        chk(req_ready == 1'b1, "R10", "ready in idle", 16'(req_ready), 16'd1);
        @(negedge clk);
        if (hold_next) begin
            req_write = nw; req_addr = na; req_wdata = nd;
        end else req_valid = 1'b0;
        for (int k = 0; k < TOT; k++) begin
            bit in_a = (k < ASH);
            bit in_h = (k >= ASH) && (k < ASH + ASL);
            bit in_d = (k >= ASH + ASL) && (k < ASH + ASL + DSH);
            bit in_e = (k == TOT - 1);
            chk(bus_addr_stb == in_a, "R3", "address strobe", 16'(bus_addr_stb), 16'(in_a));
            chk(bus_data_stb == in_d, "R4", "data strobe", 16'(bus_data_stb), 16'(in_d));
            chk(bus_rd_wr_n == !w, "R5", "direction", 16'(bus_rd_wr_n), 16'(!w));
            chk(bus_hi_addr == a[12:8], "R2", "upper address", 16'(bus_hi_addr), 16'(a[12:8]));
            chk(req_ready == 1'b0, "R10", "ready while busy", 16'(req_ready), 16'd0);
            chk(rsp_done == in_e, "R9", "done timing", 16'(rsp_done), 16'(in_e));
            if (in_a || in_h) begin
                chk(bus_ad_oe && bus_ad_out == a[7:0], "R3", "low address on shared bus",
                    {7'd0, bus_ad_oe, bus_ad_out}, {8'd1, a[7:0]});
            end else if (w) begin
                chk(bus_ad_oe && bus_ad_out == d, "R6", "write byte on shared bus",
                    {7'd0, bus_ad_oe, bus_ad_out}, {8'd1, d});
            end else begin
                chk(!bus_ad_oe, "R7", "shared bus released", 16'(bus_ad_oe), 16'd0);
            end
            if (in_e && !w)
                chk(rsp_rdata == rd_fn(a), "R8", "read byte", 16'(rsp_rdata), 16'(rd_fn(a)));
            if (in_d) begin
                int j = k - (ASH + ASL) + 1;
                bus_ad_in = (j == DSH) ? rd_fn(dev_addr) : (8'hA5 ^ 8'(j));
            end else bus_ad_in = 8'h00;
            @(negedge clk);
        end
        chk(rsp_done == 1'b0, "R9", "done drops", 16'(rsp_done), 16'd0);
        chk(req_ready == 1'b1, "R10", "ready after cycle", 16'(req_ready), 16'd1);
    endtask

    // Main sequence: reset, directed corners, then random traffic.
    initial begin
        int unsigned sd;
        sd = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        chk(!bus_addr_stb && !bus_data_stb, "R1", "strobes in reset",
            {bus_addr_stb, bus_data_stb}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_rd_wr_n && !bus_ad_oe, "R1", "direction and enable after reset",
            {bus_rd_wr_n, bus_ad_oe}, 16'd2);
        chk(req_ready && !rsp_done, "R1", "ready and done after reset",
            {req_ready, rsp_done}, 16'd2);
        xfer(1'b0, 13'h0000, 8'h00, 1'b0, 1'b0, '0, '0);
        xfer(1'b1, 13'h1FFF, 8'hFF, 1'b0, 1'b0, '0, '0);
        xfer(1'b0, 13'h1F00, 8'h00, 1'b0, 1'b0, '0, '0);
        xfer(1'b0, 13'h00FF, 8'h00, 1'b0, 1'b0, '0, '0);
        xfer(1'b1, 13'h0A5A, 8'h5A, 1'b1, 1'b0, 13'h15A5, 8'h00);
        xfer(1'b0, 13'h15A5, 8'h00, 1'b1, 1'b1, 13'h0123, 8'hC3);
        xfer(1'b1, 13'h0123, 8'hC3, 1'b0, 1'b0, '0, '0);
        for (int n = 0; n < 60; n++) begin
            bit          rw = 1'($urandom);
            logic [12:0] ra = 13'($urandom);
            logic [7:0]  rd = 8'($urandom);
            bit          hn = ($urandom % 4) == 0;
            if (hn) begin
                bit          nw2 = 1'($urandom);
                logic [12:0] na2 = 13'($urandom);
                logic [7:0]  nd2 = 8'($urandom);
                xfer(rw, ra, rd, 1'b1, nw2, na2, nd2);
                xfer(nw2, na2, nd2, 1'b0, 1'b0, '0, '0);
            end else begin
                xfer(rw, ra, rd, 1'b0, 1'b0, '0, '0);
            end
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule